// File: doc/BRIEF.md
# Watchdog Timer with Selectable Kick Source

This block supervises a processor. A free-running counter advances on every clock. If the counter reaches the timeout before something clears it, the block drives a global reset pulse of fixed length and lights a fault indicator. After the pulse the counter starts again from zero.

Two sources can clear the counter. The processor can always clear it with a kick strobe. An external oscillator tick can also clear it, but only while the block is in oscillator mode. A mode write picks the source from bit 0 of its data. After power-up the block is in oscillator mode, so firmware can boot without servicing the timer. Firmware writes 1 to hand supervision to its own kicks.

The fault indicator stays lit through the block's own reset pulses and through later expiries. The next processor kick turns it off. Only the synchronous reset input also clears it.

Top module: `kick_watchdog`

## Requirements
- R1: After the synchronous reset input `rst` is deasserted, `sys_rst_o` and `fault_led_o` are 0 and the kick source is the oscillator.
- R2: In processor mode, a pulse on `kick_wr` clears the counter. With no further kick, `sys_rst_o` rises on the TIMEOUT_CYC-th rising clock edge after the kick edge and not before. TIMEOUT_CYC = CLK_FREQ_HZ/1000*TIMEOUT_MS, so the default is 1.6 s.
- R3: In processor mode, `osc_tick` has no effect on the counter.
- R4: In oscillator mode, each `osc_tick` clears the counter, so ticks spaced closer than TIMEOUT_CYC never cause a reset. A `kick_wr` also clears the counter in this mode.
- R5: A pulse on `mode_wr` sets the kick source from `mode_data[0]` (0 = oscillator, 1 = processor). All other bits of `mode_data` are ignored.
- R6: `sys_rst_o` stays high for exactly PULSE_CYC cycles. The counter is held at zero during the pulse and restarts afterwards, so the next expiry comes TIMEOUT_CYC edges after the edge on which the pulse falls.
- R7: `fault_led_o` rises on the same edge as `sys_rst_o`. It stays high after the pulse ends and through further expiries.
- R8: A `kick_wr` pulse clears `fault_led_o` on the following edge.
- R9: An expiry returns the kick source to the oscillator.
- R10: Asserting `rst` during operation clears `sys_rst_o`, clears `fault_led_o` and restores oscillator mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| kick_wr | input | 1 | Processor kick strobe, one cycle per write |
| mode_wr | input | 1 | Mode register write strobe |
| mode_data | input | DATA_W | Mode write data; only bit 0 is used |
| osc_tick | input | 1 | One-cycle tick from the free-running oscillator |
| sys_rst_o | output | 1 | Global reset pulse, registered |
| fault_led_o | output | 1 | Latched fault indicator, registered |

## Verification
Some properties are checked by assertions on every cycle. The counter never passes its last value, and a clear is never followed by an expiry. No expiry occurs while the pulse is active, and the pulse counter stays in range. A mode write loads bit 0, and an expiry forces oscillator mode. The fault flag rises with the pulse, stays set until a kick, and drops after a kick. The directed scenarios cover what needs whole timelines: the exact edge of expiry after a kick, the pulse length and the restart interval, that ticks are ignored in processor mode, that steady ticks keep the block quiet in oscillator mode, and that mode is restored after an expiry or a reset.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef enum logic {
    KICK_OSC = 1'b0,
    KICK_CPU = 1'b1
  } kick_src_e;
endpackage

// File: rtl/wdt_src_sel.sv
module wdt_src_sel
  import wdt_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      wr,
  input  logic      sel_bit,
  input  logic      expire,
  output kick_src_e src
);
  always_ff @(posedge clk) begin
    if (rst)         src <= KICK_OSC;
    else if (expire) src <= KICK_OSC;
    else if (wr)     src <= kick_src_e'(sel_bit);
  end

  // R9: an expiry always leaves the block in oscillator mode
  a_r9_expire_to_osc: assert property (@(posedge clk) disable iff (rst)
    expire |=> src == KICK_OSC);
endmodule

// File: rtl/wdt_timeout_ctr.sv
module wdt_timeout_ctr #(
  parameter int unsigned TIMEOUT_CYC = 80_000_000
) (
  input  logic clk,
  input  logic rst,
  input  logic hold,
  input  logic clear,
  output logic expire
);
  localparam int unsigned CW = (TIMEOUT_CYC > 1) ? $clog2(TIMEOUT_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT_CYC - 1);

  logic [CW-1:0] cnt;

  assign expire = !hold && !clear && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst)                           cnt <= '0;
    else if (hold || clear || expire)  cnt <= '0;
    else                               cnt <= cnt + 1'b1;
  end

  initial begin
    a_r2_timeout_sane: assert (TIMEOUT_CYC >= 2);
  end

  // R2: the count never passes the last value before expiry
  a_r2_cnt_in_range: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST);
  // R2: a clear always buys at least one more cycle
  a_r2_clear_defers: assert property (@(posedge clk) disable iff (rst)
    clear |=> !expire);
endmodule

// File: rtl/wdt_reset_stretch.sv
module wdt_reset_stretch #(
  parameter int unsigned PULSE_CYC = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic fire,
  output logic pulse_o
);
  localparam int unsigned PW = $clog2(PULSE_CYC + 1);

  logic [PW-1:0] pcnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      pcnt    <= '0;
      pulse_o <= 1'b0;
    end else if (fire) begin
      pcnt    <= PW'(PULSE_CYC);
      pulse_o <= 1'b1;
    end else if (pcnt != '0) begin
      pcnt    <= pcnt - 1'b1;
      pulse_o <= (pcnt != PW'(1));
    end
  end

  initial begin
    a_r6_pulse_sane: assert (PULSE_CYC >= 1);
  end

  // R6: the remaining length never exceeds the configured pulse
  a_r6_len_bounded: assert property (@(posedge clk) disable iff (rst)
    pcnt <= PW'(PULSE_CYC));
  // R6: the output is high exactly while length remains
  a_r6_out_tracks: assert property (@(posedge clk) disable iff (rst)
    pulse_o == (pcnt != '0));
endmodule

// File: rtl/wdt_fault_flag.sv
module wdt_fault_flag (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic kick,
  output logic led_o
);
  always_ff @(posedge clk) begin
    if (rst)       led_o <= 1'b0;
    else if (set)  led_o <= 1'b1;
    else if (kick) led_o <= 1'b0;
  end

  // R7: once lit, only a kick turns it off
  a_r7_stays_lit: assert property (@(posedge clk) disable iff (rst)
    led_o && !kick |=> led_o);
  // R8: a kick with no new fault leaves it dark
  a_r8_kick_clears: assert property (@(posedge clk) disable iff (rst)
    kick && !set |=> !led_o);
endmodule

// File: rtl/kick_watchdog.sv
module kick_watchdog
  import wdt_pkg::*;
#(
  parameter int unsigned CLK_FREQ_HZ = 50_000_000,
  parameter int unsigned TIMEOUT_MS  = 1600,
  parameter int unsigned PULSE_CYC   = 16,
  parameter int unsigned DATA_W      = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              kick_wr,
  input  logic              mode_wr,
  input  logic [DATA_W-1:0] mode_data,
  input  logic              osc_tick,
  output logic              sys_rst_o,
  output logic              fault_led_o
);
  localparam int unsigned TIMEOUT_CYC = (CLK_FREQ_HZ / 1000) * TIMEOUT_MS;

  kick_src_e src;
  logic      clear;
  logic      expire;

  assign clear = kick_wr || ((src == KICK_OSC) && osc_tick);

  wdt_src_sel u_src (
    .clk     (clk),
    .rst     (rst),
    .wr      (mode_wr),
    .sel_bit (mode_data[0]),
    .expire  (expire),
    .src     (src)
  );

  wdt_timeout_ctr #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_ctr (
    .clk    (clk),
    .rst    (rst),
    .hold   (sys_rst_o),
    .clear  (clear),
    .expire (expire)
  );

  wdt_reset_stretch #(.PULSE_CYC(PULSE_CYC)) u_pulse (
    .clk     (clk),
    .rst     (rst),
    .fire    (expire),
    .pulse_o (sys_rst_o)
  );

  wdt_fault_flag u_fault (
    .clk   (clk),
    .rst   (rst),
    .set   (expire),
    .kick  (kick_wr),
    .led_o (fault_led_o)
  );

  // R7: the fault indicator is lit whenever the reset pulse starts
  a_r7_led_with_pulse: assert property (@(posedge clk) disable iff (rst)
    $rose(sys_rst_o) |-> fault_led_o);
  // R6: no new expiry while a pulse is in progress
  a_r6_no_retrigger: assert property (@(posedge clk) disable iff (rst)
    sys_rst_o |-> !expire);
  // R5: a mode write loads bit 0 unless an expiry overrides it
  a_r5_mode_load: assert property (@(posedge clk) disable iff (rst)
    mode_wr && !expire |=> src == kick_src_e'($past(mode_data[0])));
  // R3: in processor mode a lone tick never clears the counter
  a_r3_tick_ignored: assert property (@(posedge clk) disable iff (rst)
    (src == KICK_CPU) && !kick_wr |-> !clear);
endmodule

// File: tb/kick_watchdog_bench.sv
module kick_watchdog_bench;
  localparam int CLK_PERIOD = 10;
  localparam int FREQ  = 10_000;
  localparam int TMS   = 4;
  localparam int T     = (FREQ / 1000) * TMS;
  localparam int P     = 5;
  localparam int OSC_PER = 10;
  localparam int DW    = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic kick_wr = 1'b0;
  logic mode_wr = 1'b0;
  logic [DW-1:0] mode_data = '0;
  logic osc_tick = 1'b0;
  logic osc_on = 1'b0;
  logic sys_rst_o, fault_led_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  kick_watchdog #(.CLK_FREQ_HZ(FREQ), .TIMEOUT_MS(TMS), .PULSE_CYC(P), .DATA_W(DW))
    u_kick_watchdog (
      .clk(clk), .rst(rst), .kick_wr(kick_wr), .mode_wr(mode_wr),
      .mode_data(mode_data), .osc_tick(osc_tick),
      .sys_rst_o(sys_rst_o), .fault_led_o(fault_led_o));

  initial begin : tick_gen
    int n = 0;
    forever begin
      @(negedge clk);
      osc_tick = 1'b0;
      if (osc_on) begin
        n++;
        if (n >= OSC_PER) begin
          osc_tick = 1'b1;
          n = 0;
        end
      end else n = 0;
    end
  end

  task automatic check(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic kick();
    kick_wr = 1'b1; @(negedge clk); kick_wr = 1'b0;
  endtask

  task automatic set_mode(logic [DW-1:0] d);
    mode_data = d; mode_wr = 1'b1; @(negedge clk); mode_wr = 1'b0; mode_data = '0;
  endtask

  task automatic expect_quiet(string req, int n);
    logic seen = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (sys_rst_o) seen = 1'b1;
    end
    check(req, "no reset in window", seen, 1'b0);
  endtask

  // after a kick: low through edge T-1, high after edge T
  task automatic expect_expiry(string req);
    step(T - 1);
    check(req, "reset low before timeout", sys_rst_o, 1'b0);
    step(1);
    check(req, "reset high at timeout", sys_rst_o, 1'b1);
  endtask

  task automatic t_reset();
    check("R1", "reset output after reset", sys_rst_o, 1'b0);
    check("R1", "fault after reset", fault_led_o, 1'b0);
    osc_on = 1'b1;
    expect_quiet("R1", 3 * T);
  endtask

  task automatic t_sw_timeout();
    osc_on = 1'b0;
    set_mode(8'h01);
    kick();
    expect_expiry("R2");
    check("R7", "fault rises with pulse", fault_led_o, 1'b1);
    step(P - 1);
    check("R6", "pulse still high", sys_rst_o, 1'b1);
    step(1);
    check("R6", "pulse ended after P", sys_rst_o, 1'b0);
    check("R7", "fault held after pulse", fault_led_o, 1'b1);
    expect_expiry("R6");
    check("R7", "fault held on second expiry", fault_led_o, 1'b1);
    step(P);
    osc_on = 1'b1;
    kick();
    check("R8", "fault cleared by kick", fault_led_o, 1'b0);
  endtask

  task automatic t_sw_ignores_tick();
    osc_on = 1'b1;
    set_mode(8'h01);
    kick();
    expect_expiry("R3");
    step(P);
    // R9: now back in oscillator mode, ticks keep it quiet
    expect_quiet("R9", 3 * T);
    kick();
    check("R8", "fault cleared after R9 run", fault_led_o, 1'b0);
  endtask

  task automatic t_osc_mode();
    osc_on = 1'b1;
    set_mode(8'h00);
    expect_quiet("R4", 4 * T);
    osc_on = 1'b0;
    kick();
    expect_expiry("R4");
    step(P);
    osc_on = 1'b1;
    kick();
  endtask

  task automatic t_mode_bits();
    osc_on = 1'b1;
    set_mode(8'h01);
    set_mode(8'hFE);
    expect_quiet("R5", 3 * T);
    set_mode(8'h01);
    kick();
    expect_expiry("R5");
    step(P);
    kick();
    check("R8", "fault cleared after R5 run", fault_led_o, 1'b0);
  endtask

  task automatic t_mid_reset();
    osc_on = 1'b0;
    set_mode(8'h01);
    kick();
    step(T + 2);
    check("R10", "pulse active before reset", sys_rst_o, 1'b1);
    rst = 1'b1; step(1); rst = 1'b0;
    check("R10", "reset output cleared", sys_rst_o, 1'b0);
    check("R10", "fault cleared by rst", fault_led_o, 1'b0);
    osc_on = 1'b1;
    expect_quiet("R10", 3 * T);
  endtask

  initial begin : watchdog
    repeat (200_000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    step(3);
    rst = 1'b0;
    t_reset();
    t_sw_timeout();
    t_sw_ignores_tick();
    t_osc_mode();
    t_mode_bits();
    t_mid_reset();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule